// File: doc/BRIEF.md
# Pointer-Register Address Generation Unit

This block forms the effective address for an indirect memory access driven by a 16-bit pointer register. A single start strobe captures an addressing mode, the pointer value, a 6-bit unsigned displacement and an 8-bit extension byte. The block then presents a registered address and a memory-space select for the whole length of the operation, and it signals the last cycle with a one-cycle done pulse.

Data-space accesses take two cycles. There are three of them: a plain indirect access, a pre-decrement access in which the lowered pointer is both the address and the new pointer, and a base-plus-displacement access that leaves the pointer untouched. Program-space reads take three cycles. They come in a plain form and a post-increment form, and each of these has a 16-bit version and a version extended by the upper byte. When a pointer update applies, the block issues the new pointer value with a write enable in the done cycle. In the extended post-increment mode it also issues a new extension byte with its own enable. No mode touches any status flag, so the block has no flag output at all.

Top module: `ptr_agu`

## Requirements
- R1: Out of reset, busy_o, done_o, ptr_we_o and ext_we_o are 0 and addr_o is 0.
- R2: Mode code 0 (data, plain) drives addr_o = zero-extended pointer and space_o = 0 (data). done_o is high in the 2nd cycle after the start edge, and no write enable is raised.
- R3: Mode code 1 (data, pre-decrement) drives addr_o = pointer−1 mod 2^16 from the first cycle. In the done cycle ptr_we_o = 1 and ptr_wdata_o = pointer−1, so a pointer of 0x0000 yields 0xFFFF.
- R4: Mode code 2 (data, displacement) drives addr_o = (pointer + zero-extended displacement) mod 2^16, with space_o = 0. Neither write enable is raised.
- R5: Mode code 3 (program, plain) drives addr_o = zero-extended pointer and space_o = 1 (program). done_o is high in the 3rd cycle after the start edge, and no write enable is raised.
- R6: Mode code 4 (program, post-increment) reads at the unmodified pointer. In the done cycle ptr_we_o = 1 and ptr_wdata_o = pointer+1 mod 2^16, and ext_we_o stays 0.
- R7: Mode codes 5 (program, extended) and 6 (program, extended post-increment) drive addr_o = {extension byte, pointer}. Mode 6 treats {ext, ptr} as one 24-bit value and adds 1 to it in the done cycle: ptr_we_o and ext_we_o are both 1, and the carry out of the pointer enters ext_wdata_o.
- R8: done_o is high for exactly one cycle per operation. ptr_we_o and ext_we_o are only ever high while done_o is high.
- R9: A start during a busy cycle other than the done cycle is ignored. A start in the done cycle is accepted, and the next operation follows back to back.
- R10: Mode code 7 is reserved. A start with it is ignored: busy_o and done_o stay 0.
- R11: addr_o and space_o hold their values from the first cycle of an operation through its done cycle, even when the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| mode_i | input | 3 | Addressing mode code (0..6, 7 reserved) |
| ptr_i | input | 16 | Pointer register value |
| disp_i | input | 6 | Unsigned displacement |
| ext_i | input | 8 | Extension byte for program addresses |
| addr_o | output | 24 | Effective address |
| space_o | output | 1 | 0 = data space, 1 = program space |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | High in the final cycle of an operation |
| ptr_wdata_o | output | 16 | Updated pointer value |
| ptr_we_o | output | 1 | Pointer write enable |
| ext_wdata_o | output | 8 | Updated extension byte |
| ext_we_o | output | 1 | Extension byte write enable |

## Verification
The embedded assertions check the sequencing rules on every cycle. They confirm that done is a single-cycle pulse, that both write enables appear only alongside done, that the extension enable never fires without the pointer enable, that address and space stay frozen inside an operation, and that the latency counter stays within range. The directed scenarios are the only place that shows the arithmetic: the pre-decrement and post-increment wrap points, the displacement sum, and the carry into the extension byte. The same holds for the exact two- and three-cycle latency of each mode, for a start being rejected or accepted depending on where it lands in an operation, and for the reserved code being ignored.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;

    typedef enum logic [2:0] {
        AM_DATA_PLAIN   = 3'd0,
        AM_DATA_PREDEC  = 3'd1,
        AM_DATA_DISP    = 3'd2,
        AM_PROG_PLAIN   = 3'd3,
        AM_PROG_POSTINC = 3'd4,
        AM_PROG_EXT     = 3'd5,
        AM_PROG_EXTINC  = 3'd6,
        AM_RESERVED     = 3'd7
    } agu_mode_e;

    typedef enum logic {
        SPACE_DATA = 1'b0,
        SPACE_PROG = 1'b1
    } mem_space_e;

endpackage

// File: rtl/ptr_agu_calc.sv
module ptr_agu_calc
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int DISP_W = 6,
    parameter int EXT_W  = 8,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  agu_mode_e         mode,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DISP_W-1:0] disp,
    input  logic [EXT_W-1:0]  ext,
    output logic              valid,
    output mem_space_e        space,
    output logic [ADDR_W-1:0] ea,
    output logic              ptr_upd,
    output logic              ext_upd,
    output logic [PTR_W-1:0]  ptr_nxt,
    output logic [EXT_W-1:0]  ext_nxt
);

    logic [PTR_W-1:0]  ptr_dec;
    logic [PTR_W-1:0]  ptr_inc;
    logic [PTR_W-1:0]  ptr_disp;
    logic [ADDR_W-1:0] wide_inc;

    always_comb begin
        ptr_dec  = ptr - PTR_W'(1);
        ptr_inc  = ptr + PTR_W'(1);
        ptr_disp = ptr + PTR_W'(disp);
        wide_inc = {ext, ptr} + ADDR_W'(1);

        valid   = 1'b1;
        space   = SPACE_DATA;
        ea      = ADDR_W'(ptr);
        ptr_upd = 1'b0;
        ext_upd = 1'b0;
        ptr_nxt = ptr;
        ext_nxt = ext;

        unique case (mode)
            AM_DATA_PLAIN: ;
            AM_DATA_PREDEC: begin
                ea      = ADDR_W'(ptr_dec);
                ptr_upd = 1'b1;
                ptr_nxt = ptr_dec;
            end
            AM_DATA_DISP: begin
                ea = ADDR_W'(ptr_disp);
            end
            AM_PROG_PLAIN: begin
                space = SPACE_PROG;
            end
            AM_PROG_POSTINC: begin
                space   = SPACE_PROG;
                ptr_upd = 1'b1;
                ptr_nxt = ptr_inc;
            end
            AM_PROG_EXT: begin
                space = SPACE_PROG;
                ea    = {ext, ptr};
            end
            AM_PROG_EXTINC: begin
                space   = SPACE_PROG;
                ea      = {ext, ptr};
                ptr_upd = 1'b1;
                ext_upd = 1'b1;
                ptr_nxt = wide_inc[PTR_W-1:0];
                ext_nxt = wide_inc[ADDR_W-1:PTR_W];
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ptr_agu_timer.sv
module ptr_agu_timer #(
    parameter int MAX_LAT = 3,
    localparam int CW = $clog2(MAX_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] lat,
    output logic          busy,
    output logic          last
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] rem;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.busy = 1'b1;
            tmr_d.rem  = lat - CW'(1);
        end else if (tmr_q.busy) begin
            if (tmr_q.rem == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.rem = tmr_q.rem - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;
    assign last = tmr_q.busy && (tmr_q.rem == '0);

    // R8: remaining count never exceeds the longest latency
    p_rem_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.rem <= CW'(MAX_LAT - 1));

    // R8: a final cycle ends the operation unless a new one is loaded
    p_last_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !load) |=> !busy);

endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int PTR_W    = 16,
    parameter int DISP_W   = 6,
    parameter int EXT_W    = 8,
    parameter int DATA_LAT = 2,
    parameter int PROG_LAT = 3,
    localparam int ADDR_W  = PTR_W + EXT_W,
    localparam int MAX_LAT = (DATA_LAT > PROG_LAT) ? DATA_LAT : PROG_LAT,
    localparam int CW      = $clog2(MAX_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [EXT_W-1:0]  ext_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              space_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [PTR_W-1:0]  ptr_wdata_o,
    output logic              ptr_we_o,
    output logic [EXT_W-1:0]  ext_wdata_o,
    output logic              ext_we_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        mem_space_e        space;
        logic              ptr_upd;
        logic              ext_upd;
        logic [PTR_W-1:0]  ptr_nxt;
        logic [EXT_W-1:0]  ext_nxt;
    } op_t;

    op_t op_d, op_q;

    logic              c_valid;
    mem_space_e        c_space;
    logic [ADDR_W-1:0] c_ea;
    logic              c_ptr_upd;
    logic              c_ext_upd;
    logic [PTR_W-1:0]  c_ptr_nxt;
    logic [EXT_W-1:0]  c_ext_nxt;
    logic              t_busy;
    logic              t_last;
    logic              accept;
    logic [CW-1:0]     lat_sel;

    ptr_agu_calc #(
        .PTR_W  (PTR_W),
        .DISP_W (DISP_W),
        .EXT_W  (EXT_W)
    ) u_calc (
        .mode    (agu_mode_e'(mode_i)),
        .ptr     (ptr_i),
        .disp    (disp_i),
        .ext     (ext_i),
        .valid   (c_valid),
        .space   (c_space),
        .ea      (c_ea),
        .ptr_upd (c_ptr_upd),
        .ext_upd (c_ext_upd),
        .ptr_nxt (c_ptr_nxt),
        .ext_nxt (c_ext_nxt)
    );

    ptr_agu_timer #(
        .MAX_LAT (MAX_LAT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .lat   (lat_sel),
        .busy  (t_busy),
        .last  (t_last)
    );

    always_comb begin
        accept  = start_i && c_valid && (!t_busy || t_last);
        lat_sel = (c_space == SPACE_PROG) ? CW'(PROG_LAT) : CW'(DATA_LAT);
        op_d    = op_q;
        if (accept) begin
            op_d.addr    = c_ea;
            op_d.space   = c_space;
            op_d.ptr_upd = c_ptr_upd;
            op_d.ext_upd = c_ext_upd;
            op_d.ptr_nxt = c_ptr_nxt;
            op_d.ext_nxt = c_ext_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
        end else begin
            op_q <= op_d;
        end
    end

    assign addr_o      = op_q.addr;
    assign space_o     = op_q.space;
    assign busy_o      = t_busy;
    assign done_o      = t_last;
    assign ptr_wdata_o = op_q.ptr_nxt;
    assign ptr_we_o    = t_last && op_q.ptr_upd;
    assign ext_wdata_o = op_q.ext_nxt;
    assign ext_we_o    = t_last && op_q.ext_upd;

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: pointer write-back only in the done cycle
    p_ptr_we_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we_o |-> done_o);

    // R7: extension write-back always comes with a pointer write-back
    p_ext_we_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we_o |-> ptr_we_o);

    // R11: address held inside an operation
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(addr_o));

    // R11: space held inside an operation
    p_space_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(space_o));

    // R10: the reserved code never starts an operation from idle
    p_rsvd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && mode_i == 3'd7) |=> !busy_o);

endmodule

// File: tb/ptr_agu_tb.sv
`timescale 1ns/1ps
module ptr_agu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] ptr_i = 16'h0;
    logic [5:0]  disp_i = 6'h0;
    logic [7:0]  ext_i = 8'h0;
    logic [23:0] addr_o;
    logic        space_o;
    logic        busy_o;
    logic        done_o;
    logic [15:0] ptr_wdata_o;
    logic        ptr_we_o;
    logic [7:0]  ext_wdata_o;
    logic        ext_we_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ptr_agu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .ptr_i       (ptr_i),
        .disp_i      (disp_i),
        .ext_i       (ext_i),
        .addr_o      (addr_o),
        .space_o     (space_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ptr_wdata_o (ptr_wdata_o),
        .ptr_we_o    (ptr_we_o),
        .ext_wdata_o (ext_wdata_o),
        .ext_we_o    (ext_we_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic launch(input logic [2:0] m, input logic [15:0] p,
                          input logic [5:0] d, input logic [7:0] e);
        mode_i  = m;
        ptr_i   = p;
        disp_i  = d;
        ext_i   = e;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ptr_i   = ~p;
        disp_i  = ~d;
        ext_i   = ~e;
    endtask

    // Caller is at a negedge; launches, then checks every cycle up to done.
    task automatic run_op(input string req, input logic [2:0] m,
                          input logic [15:0] p, input logic [5:0] d,
                          input logic [7:0] e, input int lat,
                          input logic [23:0] exp_addr, input logic exp_space,
                          input logic exp_pwe, input logic [15:0] exp_pw,
                          input logic exp_ewe, input logic [7:0] exp_ew);
        launch(m, p, d, e);
        for (int c = 1; c <= lat; c++) begin
            chk(addr_o == exp_addr, req, "addr", 32'(addr_o), 32'(exp_addr));
            chk(space_o == exp_space, req, "space", 32'(space_o), 32'(exp_space));
            chk(busy_o == 1'b1, req, "busy", 32'(busy_o), 32'd1);
            chk(done_o == (c == lat), req, "done timing", 32'(done_o), 32'(c == lat));
            if (c == lat) begin
                chk(ptr_we_o == exp_pwe, req, "ptr_we", 32'(ptr_we_o), 32'(exp_pwe));
                if (exp_pwe)
                    chk(ptr_wdata_o == exp_pw, req, "ptr_wdata", 32'(ptr_wdata_o), 32'(exp_pw));
                chk(ext_we_o == exp_ewe, req, "ext_we", 32'(ext_we_o), 32'(exp_ewe));
                if (exp_ewe)
                    chk(ext_wdata_o == exp_ew, req, "ext_wdata", 32'(ext_wdata_o), 32'(exp_ew));
            end else begin
                chk(!ptr_we_o && !ext_we_o, "R8", "early we", 32'({ptr_we_o, ext_we_o}), 32'd0);
            end
            @(negedge clk);
        end
        chk(!done_o && !busy_o, "R8", "after done", 32'({busy_o, done_o}), 32'd0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !ptr_we_o && !ext_we_o, "R1", "ctl",
            32'({busy_o, done_o, ptr_we_o, ext_we_o}), 32'd0);
        chk(addr_o == 24'h0, "R1", "addr", 32'(addr_o), 32'd0);
    endtask

    task automatic t_data_plain();
        run_op("R2", 3'd0, 16'h1234, 6'd9, 8'h55, 2, 24'h001234, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
        run_op("R2", 3'd0, 16'hFFFF, 6'd0, 8'hAA, 2, 24'h00FFFF, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
    endtask

    task automatic t_predec();
        run_op("R3", 3'd1, 16'h0100, 6'd0, 8'h00, 2, 24'h0000FF, 1'b0, 1'b1, 16'h00FF, 1'b0, 8'h0);
        run_op("R3", 3'd1, 16'h0000, 6'd3, 8'h44, 2, 24'h00FFFF, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h0);
    endtask

    task automatic t_disp();
        run_op("R4", 3'd2, 16'h2000, 6'd63, 8'h11, 2, 24'h00203F, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
        run_op("R4", 3'd2, 16'hFFF0, 6'd32, 8'h11, 2, 24'h000010, 1'b0, 1'b0, 16'h0, 1'b0, 8'h0);
    endtask

    task automatic t_prog_plain();
        run_op("R5", 3'd3, 16'hBEEF, 6'd5, 8'h77, 3, 24'h00BEEF, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
    endtask

    task automatic t_postinc();
        run_op("R6", 3'd4, 16'h00FF, 6'd0, 8'h12, 3, 24'h0000FF, 1'b1, 1'b1, 16'h0100, 1'b0, 8'h0);
        run_op("R6", 3'd4, 16'hFFFF, 6'd0, 8'h12, 3, 24'h00FFFF, 1'b1, 1'b1, 16'h0000, 1'b0, 8'h0);
    endtask

    task automatic t_ext();
        run_op("R7", 3'd5, 16'h4321, 6'd0, 8'h3C, 3, 24'h3C4321, 1'b1, 1'b0, 16'h0, 1'b0, 8'h0);
        run_op("R7", 3'd6, 16'h8000, 6'd0, 8'h12, 3, 24'h128000, 1'b1, 1'b1, 16'h8001, 1'b1, 8'h12);
        run_op("R7", 3'd6, 16'hFFFF, 6'd0, 8'h12, 3, 24'h12FFFF, 1'b1, 1'b1, 16'h0000, 1'b1, 8'h13);
        run_op("R7", 3'd6, 16'hFFFF, 6'd0, 8'hFF, 3, 24'hFFFFFF, 1'b1, 1'b1, 16'h0000, 1'b1, 8'h00);
    endtask

    task automatic t_busy_ignore();
        launch(3'd3, 16'h0A0A, 6'd0, 8'h00);
        // cycle 1: attempt a new start, must be ignored
        mode_i = 3'd0; ptr_i = 16'h5555; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(addr_o == 24'h000A0A, "R9", "addr kept", 32'(addr_o), 32'h0A0A);
        chk(space_o == 1'b1 && !done_o, "R9", "space/done c2",
            32'({space_o, done_o}), 32'b10);
        @(negedge clk);
        chk(done_o == 1'b1, "R9", "done c3", 32'(done_o), 32'd1);
        @(negedge clk);
        chk(!busy_o && !done_o, "R9", "no extra op", 32'({busy_o, done_o}), 32'd0);
    endtask

    task automatic t_back_to_back();
        launch(3'd0, 16'h0300, 6'd0, 8'h00);
        @(negedge clk);
        chk(done_o == 1'b1, "R9", "first done", 32'(done_o), 32'd1);
        run_op("R9", 3'd1, 16'h0400, 6'd0, 8'h00, 2, 24'h0003FF, 1'b0, 1'b1, 16'h03FF, 1'b0, 8'h0);
    endtask

    task automatic t_reserved();
        logic [23:0] a0;
        a0 = addr_o;
        launch(3'd7, 16'h7777, 6'd1, 8'h01);
        for (int c = 0; c < 4; c++) begin
            chk(!busy_o && !done_o && !ptr_we_o, "R10", "idle",
                32'({busy_o, done_o, ptr_we_o}), 32'd0);
            @(negedge clk);
        end
        chk(addr_o == a0, "R10", "addr untouched", 32'(addr_o), 32'(a0));
    endtask

    task automatic t_hold();
        launch(3'd5, 16'h1111, 6'd0, 8'h22);
        ptr_i = 16'h9999; ext_i = 8'h88; mode_i = 3'd0;
        @(negedge clk);
        chk(addr_o == 24'h221111 && space_o, "R11", "held c2", 32'(addr_o), 32'h221111);
        @(negedge clk);
        chk(addr_o == 24'h221111 && done_o, "R11", "held c3", 32'(addr_o), 32'h221111);
        @(negedge clk);
    endtask

    initial begin
        #100_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_plain();
        t_predec();
        t_disp();
        t_prog_plain();
        t_postinc();
        t_ext();
        t_busy_ignore();
        t_back_to_back();
        t_reserved();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule